// File: doc/BRIEF.md
# Sticky Event Status and Interrupt Controller

This block collects events from a peripheral and from four external interrupt lines into a sticky status register. Each status bit stays set until software clears it by writing a one to that position. A separate enable register picks which status bits may raise the level interrupt to the local core. That interrupt stays high for as long as any enabled status bit is set.

A small control register handles the two shared board lines. One is the first external interrupt line, and it can be turned around to act as an output. The other is the bus reset line. For each of these lines, one control bit sets the pad direction and a second bit asks for the line to be pulled low. Both outputs are active-low open-drain: the block gives a drive enable and a value that is always zero. The other three interrupt lines are inputs only. A bus reset seen on the reset input is itself an event, and it lands in status bit 6.

Software reaches the block through a plain register port. A write is done with a one-cycle write strobe. A read is combinational from the address.

Top module: `sticky_irq_ctrl`

## Requirements
- R1: An event, whether a local event input bit or a pin event, sets its status bit at the next clock edge. The bit then stays set after the event goes away.
- R2: A write to address 0 clears every status bit whose written data bit is 1. A written 0 leaves that status bit unchanged.
- R3: If an event and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R4: `coreIrq` is high exactly while at least one status bit is set and its enable bit (address 1) is also 1. A status bit whose enable bit is 0 never raises `coreIrq`.
- R5: Interrupt lines A to D (`intLineN[0]` to `intLineN[3]`) are active low and map to status bits 0 to 3. Each passes through a two-flop synchronizer. A line pulled low before edge k sets its status bit at edge k+2 and not earlier.
- R6: `busRstN` low is an event on status bit 6, with the same two-flop latency as R5.
- R7: The control register sits at address 2 with these bits: bit 0 = line A direction is output, bit 1 = line A assert request, bit 2 = reset line direction is output, bit 3 = reset assert request. `lineADrvEn` is 1 only when bits 0 and 1 are both 1. `rstDrvEn` is 1 only when bits 2 and 3 are both 1. `lineADrvVal` and `rstDrvVal` are always 0.
- R8: While control bit 0 is 1, a low level on line A does not set status bit 0. While control bit 2 is 1, a low `busRstN` does not set status bit 6.
- R9: After reset, the status, enable and control registers are all 0, `coreIrq` is 0 and neither drive enable is active.
- R10: Reads return the following: address 0 gives status, address 1 gives enable, address 2 gives control in bits 3:0 with zeros above, and address 3 gives the synchronized pin levels {zeros, busRstN, D, C, B, A}. A write to address 3 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wrData | input | NUM_EVT | Write data |
| rdData | output | NUM_EVT | Read data for `addr` |
| intLineN | input | 4 | External interrupt lines A..D, active low |
| busRstN | input | 1 | Bus reset line level, active low |
| localEvt | input | NUM_EVT | Local event pulses, one per status bit |
| coreIrq | output | 1 | Level interrupt to the local core |
| lineADrvEn | output | 1 | Open-drain drive enable for line A |
| lineADrvVal | output | 1 | Drive value for line A (constant 0) |
| rstDrvEn | output | 1 | Open-drain drive enable for the reset line |
| rstDrvVal | output | 1 | Drive value for the reset line (constant 0) |

## Verification
The assertions check three properties on every cycle. First, a set status bit can only drop through a write of one, and any event shows in status on the next edge, even against a clear. Second, the core interrupt cannot fall unless software writes status or enable. Third, a drive enable only rises after a control write. The bench scenarios cover what the assertions cannot: the exact two-edge synchronizer latency, the masking of a pin's own event while the block drives that pin, the read map, and the need for both the direction bit and the request bit before a drive. A reference model checks long random mixes of events and writes.

// File: rtl/sticky_irq_pkg.sv
package sticky_irq_pkg;
  localparam int NUM_LINES = 4;
  localparam int CTRL_W    = 4;
  localparam int RST_EVT   = 6;

  typedef enum logic [1:0] {
    ADDR_STATUS  = 2'd0,
    ADDR_ENABLE  = 2'd1,
    ADDR_CONTROL = 2'd2,
    ADDR_PINS    = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic wrStatus;
    logic wrEnable;
    logic wrControl;
  } regStrobe_t;
endpackage

// File: rtl/sticky_irq_decode.sv
module sticky_irq_decode
  import sticky_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  output regStrobe_t strb
);
  always_comb begin
    strb = '0;
    if (wrEn) begin
      case (regAddr_e'(addr))
        ADDR_STATUS:  strb.wrStatus  = 1'b1;
        ADDR_ENABLE:  strb.wrEnable  = 1'b1;
        ADDR_CONTROL: strb.wrControl = 1'b1;
        default:      strb = '0;
      endcase
    end
  end

  // R10: at most one register written per cycle; pin address writes nothing
  assert_strobe_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrStatus, strb.wrEnable, strb.wrControl}));
endmodule

// File: rtl/sticky_irq_datapath.sv
module sticky_irq_datapath
  import sticky_irq_pkg::*;
#(
  parameter int NUM_EVT     = 8,
  parameter int SYNC_STAGES = 2
)(
  input  logic               clk,
  input  logic               rstN,
  input  regStrobe_t         strb,
  input  logic [1:0]         addr,
  input  logic [NUM_EVT-1:0] wrData,
  output logic [NUM_EVT-1:0] rdData,
  input  logic [NUM_LINES-1:0] intLineN,
  input  logic               busRstN,
  input  logic [NUM_EVT-1:0] localEvt,
  output logic               coreIrq,
  output logic               lineADrvEn,
  output logic               lineADrvVal,
  output logic               rstDrvEn,
  output logic               rstDrvVal
);
  localparam int PIN_W = NUM_LINES + 1;

  logic [PIN_W-1:0]   syncQ [SYNC_STAGES];
  logic [PIN_W-1:0]   pinLvl;
  logic [NUM_EVT-1:0] statusQ, enableQ, pinEvt, evtVec, clrVec;
  logic [CTRL_W-1:0]  ctrlQ;
  logic               dirA, reqA, dirRst, reqRst;

  assign dirA   = ctrlQ[0];
  assign reqA   = ctrlQ[1];
  assign dirRst = ctrlQ[2];
  assign reqRst = ctrlQ[3];

  // Pin synchronizer, idle level high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '1;
    end else begin
      syncQ[0] <= {busRstN, intLineN};
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign pinLvl = syncQ[SYNC_STAGES-1];

  // A pin the block drives does not report its own level as an event
  always_comb begin
    pinEvt = '0;
    pinEvt[NUM_LINES-1:0] = ~pinLvl[NUM_LINES-1:0];
    pinEvt[0]       = ~pinLvl[0] & ~dirA;
    pinEvt[RST_EVT] = ~pinLvl[NUM_LINES] & ~dirRst;
  end

  assign evtVec = localEvt | pinEvt;
  assign clrVec = strb.wrStatus ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      ctrlQ   <= '0;
    end else begin
      statusQ <= (statusQ & ~clrVec) | evtVec;
      if (strb.wrEnable)  enableQ <= wrData;
      if (strb.wrControl) ctrlQ   <= wrData[CTRL_W-1:0];
    end
  end

  assign coreIrq     = |(statusQ & enableQ);
  assign lineADrvEn  = dirA & reqA;
  assign rstDrvEn    = dirRst & reqRst;
  assign lineADrvVal = 1'b0;
  assign rstDrvVal   = 1'b0;

  always_comb begin
    rdData = '0;
    case (regAddr_e'(addr))
      ADDR_STATUS:  rdData = statusQ;
      ADDR_ENABLE:  rdData = enableQ;
      ADDR_CONTROL: rdData[CTRL_W-1:0] = ctrlQ;
      default:      rdData[PIN_W-1:0]  = pinLvl;
    endcase
  end

  // R1/R2: a set bit survives unless a one was written to it
  assert_sticky_R1: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(statusQ) & ~$past(clrVec)) & ~statusQ) == '0));
  // R3: every event is visible in status on the next edge, even against a clear
  assert_event_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(evtVec) & ~statusQ) == '0));
  // R4: the level interrupt cannot drop without a status or enable write
  assert_irq_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coreIrq && !strb.wrStatus && !strb.wrEnable) |=> coreIrq);
  // R7: drives only start after a control write
  assert_drive_start_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(lineADrvEn) || $rose(rstDrvEn)) |-> $past(strb.wrControl));
endmodule

// File: rtl/sticky_irq_ctrl.sv
module sticky_irq_ctrl
  import sticky_irq_pkg::*;
#(
  parameter int NUM_EVT = 8
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [1:0]         addr,
  input  logic [NUM_EVT-1:0] wrData,
  output logic [NUM_EVT-1:0] rdData,
  input  logic [3:0]         intLineN,
  input  logic               busRstN,
  input  logic [NUM_EVT-1:0] localEvt,
  output logic               coreIrq,
  output logic               lineADrvEn,
  output logic               lineADrvVal,
  output logic               rstDrvEn,
  output logic               rstDrvVal
);
  regStrobe_t strb;

  sticky_irq_decode uDecode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .strb(strb)
  );

  sticky_irq_datapath #(.NUM_EVT(NUM_EVT), .SYNC_STAGES(2)) uPath (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .wrData(wrData),
    .rdData(rdData), .intLineN(intLineN), .busRstN(busRstN),
    .localEvt(localEvt), .coreIrq(coreIrq), .lineADrvEn(lineADrvEn),
    .lineADrvVal(lineADrvVal), .rstDrvEn(rstDrvEn), .rstDrvVal(rstDrvVal)
  );
endmodule

// File: tb/tb_sticky_irq_ctrl.sv
`timescale 1ns/1ps
module tb_sticky_irq_ctrl;
  localparam int NE = 8;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, busRstN = 1'b1;
  logic [1:0] addr = '0;
  logic [NE-1:0] wrData = '0, localEvt = '0, rdData;
  logic [3:0] intLineN = 4'hF;
  logic coreIrq, lineADrvEn, lineADrvVal, rstDrvEn, rstDrvVal;
  int checks = 0, fails = 0;
  bit useModel = 0;
  logic [NE-1:0] mStatus = '0, mEnable = '0;
  logic [3:0] mCtrl = '0;

  always #2 clk = ~clk;

  sticky_irq_ctrl #(.NUM_EVT(NE)) dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .intLineN(intLineN), .busRstN(busRstN), .localEvt(localEvt),
    .coreIrq(coreIrq), .lineADrvEn(lineADrvEn), .lineADrvVal(lineADrvVal),
    .rstDrvEn(rstDrvEn), .rstDrvVal(rstDrvVal)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic expIrq(logic [NE-1:0] s, logic [NE-1:0] e);
    return |(s & e);
  endfunction

  task automatic step();
    @(posedge clk);
    if (useModel) begin
      if (wrEn && addr == 2'd0) mStatus = mStatus & ~wrData;
      mStatus = mStatus | localEvt;
      if (wrEn && addr == 2'd1) mEnable = wrData;
      if (wrEn && addr == 2'd2) mCtrl = wrData[3:0];
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [1:0] a, logic [NE-1:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    step();
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [NE-1:0] d);
    addr = a; #1; d = rdData;
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [NE-1:0] v;
    process::self().srandom(32'h5EED_1234);
    steps(3);
    rstN = 1'b1;
    step();
    // R9 reset state
    rd(0, v); chk("R9 status", v, 0);
    rd(1, v); chk("R9 enable", v, 0);
    rd(2, v); chk("R9 control", v, 0);
    chk("R9 irq/drive", {coreIrq, lineADrvEn, rstDrvEn}, 0);

    // R1 sticky, R4 disabled bit gives no irq
    localEvt = 8'h20; step(); localEvt = '0; steps(2);
    rd(0, v); chk("R1 sticky", v, 8'h20);
    chk("R4 disabled no irq", coreIrq, 0);
    wr(1, 8'h20); chk("R4 enabled irq", coreIrq, 1);
    steps(3); chk("R4 irq stays level", coreIrq, 1);
    wr(1, 8'h00); chk("R4 enable off", coreIrq, 0);
    // R2 write-one-to-clear
    wr(0, 8'hDF); rd(0, v); chk("R2 zero no effect", v, 8'h20);
    wr(0, 8'h20); rd(0, v); chk("R2 one clears", v, 0);
    // R3 event wins over clear
    localEvt = 8'h04; wr(0, 8'h04); localEvt = '0;
    rd(0, v); chk("R3 event wins", v, 8'h04);
    wr(0, 8'h04); rd(0, v); chk("R3 then cleared", v, 0);

    // R5 line C latency
    intLineN = 4'b1011; steps(2);
    rd(0, v); chk("R5 not before k+2", v, 0);
    step(); rd(0, v); chk("R5 set at k+2", v, 8'h04);
    intLineN = 4'hF; steps(3); wr(0, 8'hFF);
    rd(0, v); chk("R5 clear after release", v, 0);

    // R6 bus reset event
    busRstN = 1'b0; steps(3);
    rd(0, v); chk("R6 reset event bit6", v, 8'h40);
    wr(1, 8'h40); chk("R6 reset irq", coreIrq, 1);
    busRstN = 1'b1; steps(3); wr(0, 8'h40);
    chk("R6 irq after clear", coreIrq, 0);
    wr(1, 8'h00);

    // R7 drive control
    wr(2, 8'h02); chk("R7 request only", {lineADrvEn, rstDrvEn}, 0);
    wr(2, 8'h03); chk("R7 line A drive", {lineADrvEn, lineADrvVal, rstDrvEn}, 3'b100);
    wr(2, 8'h04); chk("R7 reset dir only", {lineADrvEn, rstDrvEn}, 0);
    wr(2, 8'h0C); chk("R7 reset drive", {lineADrvEn, rstDrvEn, rstDrvVal}, 3'b010);
    rd(2, v); chk("R10 control read", v, 8'h0C);

    // R8 own-drive masking
    wr(2, 8'h05); intLineN = 4'hE; busRstN = 1'b0; steps(4);
    rd(0, v); chk("R8 masked while output", v, 0);
    chk("R8 no drive without request", {lineADrvEn, rstDrvEn}, 0);
    wr(2, 8'h00); step();
    rd(0, v); chk("R8 unmasked as input", v, 8'h41);
    intLineN = 4'hF; busRstN = 1'b1; steps(3); wr(0, 8'hFF);

    // R10 pin read and ignored write
    intLineN = 4'b0101; steps(2);
    rd(3, v); chk("R10 pin levels", v, 8'h15);
    intLineN = 4'hF; steps(3); wr(0, 8'hFF);
    wr(3, 8'hFF);
    rd(0, v); chk("R10 addr3 write status", v, 0);
    rd(1, v); chk("R10 addr3 write enable", v, 0);
    rd(2, v); chk("R10 addr3 write control", v, 0);

    // Random mix against model (R1 R2 R3 R4)
    mStatus = '0; mEnable = '0; mCtrl = '0; useModel = 1;
    for (int it = 0; it < 400; it++) begin
      localEvt = ($urandom % 3 == 0) ? NE'(1 << ($urandom % NE)) : '0;
      if ($urandom % 3 == 0) begin
        wrEn = 1'b1; addr = 2'($urandom % 3); wrData = NE'($urandom);
      end
      step();
      wrEn = 1'b0; wrData = '0; localEvt = '0;
      rd(0, v); chk("R1 R2 R3 random status", v, mStatus);
      chk("R4 random irq", coreIrq, expIrq(mStatus, mEnable));
      chk("R7 random drive", {lineADrvEn, rstDrvEn}, {mCtrl[0] & mCtrl[1], mCtrl[2] & mCtrl[3]});
    end
    useModel = 0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule